// File: doc/BRIEF.md
# Training Ordered Set Receiver

This block sits behind the symbol aligner and 8b/10b decoder of one serial lane. Each clock it may take one decoded symbol: an 8-bit value, a flag that marks a control (K) character, and a strobe that says whether the symbol is present. It searches the stream for 16-symbol training sets that open with the COM control character. It checks the structure of every candidate set and tells the proposing kind (TS1) from the confirming kind (TS2). From each set it extracts the link number, lane number, fast-training-sequence count, rate field and the four training-control bits.

A link number or lane number received as the PAD control character means "not assigned yet". It is reported through a separate flag, not as a numeric value. Every COM character also produces a one-cycle pulse that the descrambler uses to reseed its LFSR. A saturating run counter reports how many completed sets in a row were identical to the one before. The link training state machine uses this count for its "N consecutive sets" exit conditions.

Top module: `ts_rx`

## Requirements
- R1: While `rst_n` is low, `set_valid`, `scr_reset`, `run_count`, every captured field and both PAD flags are 0.
- R2: A symbol with `sym_k`=1 and value 0xBC (COM) accepted while `sym_valid`=1 produces `scr_reset`=1 in the following cycle only. There is exactly one pulse per accepted COM.
- R3: When the 16th symbol of a well-formed set is accepted, `set_valid` is high for exactly one cycle after that clock edge. `set_is_ts2` is 0 when symbols 6 to 15 are all data 0x4A, and 1 when they are all data 0x45.
- R4: Symbol 1 gives the link number. A data symbol sets `link_num` to its value with `link_pad`=0. PAD (`sym_k`=1, value 0xF7) sets `link_pad`=1 with `link_num`=0.
- R5: Symbol 2 gives the lane number, with the same data/PAD rule through `lane_num` and `lane_pad`.
- R6: Symbol 3 is reported as `fts_num` and symbol 4 as `rate_code`. `train_ctrl` takes bits 3:0 of symbol 5: bit0 hot reset, bit1 loopback, bit2 disable scrambling, bit3 compliance receive. Bits 7:4 of symbol 5 are ignored.
- R7: If any of symbols 6 to 15 is not a data symbol equal to the identifier seen in symbol 6, or symbol 6 is neither 0x4A nor 0x45, the set is dropped. No `set_valid` follows, and the captured fields and `run_count` keep their values.
- R8: The set is dropped in the same way when a control character other than COM or PAD arrives in symbol 1 or 2, or any control character other than COM arrives in symbols 3 to 5.
- R9: A COM received inside a set discards the partial set, and the next symbol is parsed as symbol 1.
- R10: When a set completes, `run_count` becomes the previous count plus one, held at 15, if all reported fields and the kind equal those of the last completed set. Otherwise it becomes 0. The first set after reset gives 0, and dropped sets do not change the count or the chain.
- R11: Cycles with `sym_valid`=0 are ignored, whatever `sym_k` and `sym_data` hold, and parsing resumes at the same symbol position.
- R12: Between completed sets the captured fields, `set_is_ts2` and `run_count` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | A symbol is present this cycle |
| sym_k | input | 1 | Symbol is a control (K) character |
| sym_data | input | 8 | Decoded symbol value |
| set_valid | output | 1 | One-cycle pulse: a complete set was received |
| set_is_ts2 | output | 1 | 1 for a confirming set (TS2), 0 for a proposing set (TS1) |
| link_num | output | 8 | Link number, 0 when PAD |
| link_pad | output | 1 | Link number was PAD |
| lane_num | output | 8 | Lane number, 0 when PAD |
| lane_pad | output | 1 | Lane number was PAD |
| fts_num | output | 8 | Fast training sequences requested |
| rate_code | output | 8 | Advertised data rate field |
| train_ctrl | output | 4 | Training-control bits (hot reset, loopback, disable scrambling, compliance receive) |
| run_count | output | 4 | Consecutive identical sets, saturating at 15 |
| scr_reset | output | 1 | Pulse one cycle after each accepted COM |

## Verification
All results of the block leave through one register stage. `scr_reset` rises in the cycle after the clock edge that takes a COM. `set_valid`, the fields and `run_count` change together in the cycle after the edge that takes the 16th symbol. The bench drives each symbol at a falling edge and samples every output at the next falling edge. That is half a cycle after the rising edge where the result is due. It pops the expected set from its queue exactly when `set_valid` is seen, and counts COM pulses against COMs sent. After each dropped set it reads the held count and fields directly at the ports.

// File: rtl/ts_rx_pkg.sv
package ts_rx_pkg;

  localparam int SYM_W  = 8;
  localparam int CTRL_W = 4;

  localparam logic [SYM_W-1:0] SYM_COM = 8'hBC;
  localparam logic [SYM_W-1:0] SYM_PAD = 8'hF7;
  localparam logic [SYM_W-1:0] ID_TS1  = 8'h4A;
  localparam logic [SYM_W-1:0] ID_TS2  = 8'h45;

  typedef enum logic [1:0] {
    SC_DATA  = 2'd0,
    SC_COM   = 2'd1,
    SC_PAD   = 2'd2,
    SC_KOTH  = 2'd3
  } sym_class_e;

  typedef struct packed {
    logic              is_ts2;
    logic              link_pad;
    logic [SYM_W-1:0]  link;
    logic              lane_pad;
    logic [SYM_W-1:0]  lane;
    logic [SYM_W-1:0]  fts;
    logic [SYM_W-1:0]  rate;
    logic [CTRL_W-1:0] ctrl;
  } ts_fields_t;

  function automatic sym_class_e classify_sym(input logic k, input logic [SYM_W-1:0] d);
    if (!k)               return SC_DATA;
    else if (d == SYM_COM) return SC_COM;
    else if (d == SYM_PAD) return SC_PAD;
    else                   return SC_KOTH;
  endfunction

  function automatic int unsigned next_run(input int unsigned cur,
                                           input int unsigned cap,
                                           input logic        same);
    if (!same)       return 0;
    else if (cur >= cap) return cap;
    else             return cur + 1;
  endfunction

endpackage

// File: rtl/ts_sym_classify.sv
module ts_sym_classify
  import ts_rx_pkg::*;
(
  input  logic             sym_k,
  input  logic [SYM_W-1:0] sym_data,
  output sym_class_e       cls,
  output logic             is_id_ts1,
  output logic             is_id_ts2
);

  always_comb begin
    cls       = classify_sym(sym_k, sym_data);
    is_id_ts1 = (cls == SC_DATA) && (sym_data == ID_TS1);
    is_id_ts2 = (cls == SC_DATA) && (sym_data == ID_TS2);
  end

endmodule

// File: rtl/ts_frame_parser.sv
module ts_frame_parser
  import ts_rx_pkg::*;
#(
  parameter int SET_LEN = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid,
  input  sym_class_e       cls,
  input  logic [SYM_W-1:0] sym_data,
  input  logic             is_id_ts1,
  input  logic             is_id_ts2,
  output logic             com_evt,
  output logic             done_evt,
  output logic             abort_evt,
  output ts_fields_t       fields_o
);

  localparam int POS_W = $clog2(SET_LEN);
  localparam logic [POS_W-1:0] P_LINK = POS_W'(1);
  localparam logic [POS_W-1:0] P_LANE = POS_W'(2);
  localparam logic [POS_W-1:0] P_FTS  = POS_W'(3);
  localparam logic [POS_W-1:0] P_RATE = POS_W'(4);
  localparam logic [POS_W-1:0] P_CTRL = POS_W'(5);
  localparam logic [POS_W-1:0] P_ID   = POS_W'(6);
  localparam logic [POS_W-1:0] P_LAST = POS_W'(SET_LEN - 1);

  logic             active_q;
  logic [POS_W-1:0] pos_q;
  ts_fields_t       shadow_q;
  logic             take;
  logic             sym_ok;

  // Symbol legality at the current position
  always_comb begin
    if (pos_q == P_LINK || pos_q == P_LANE)
      sym_ok = (cls == SC_DATA) || (cls == SC_PAD);
    else if (pos_q < P_ID)
      sym_ok = (cls == SC_DATA);
    else if (pos_q == P_ID)
      sym_ok = is_id_ts1 || is_id_ts2;
    else
      sym_ok = shadow_q.is_ts2 ? is_id_ts2 : is_id_ts1;
  end

  assign com_evt   = sym_valid && (cls == SC_COM);
  assign take      = sym_valid && active_q && (cls != SC_COM);
  assign abort_evt = take && !sym_ok;
  assign done_evt  = take && sym_ok && (pos_q == P_LAST);

  always_comb begin
    fields_o = shadow_q;
    if (pos_q == P_ID) fields_o.is_ts2 = is_id_ts2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pos_q    <= '0;
      shadow_q <= '0;
    end else if (com_evt) begin
      active_q <= 1'b1;
      pos_q    <= P_LINK;
      shadow_q <= '0;
    end else if (take) begin
      if (!sym_ok || pos_q == P_LAST) active_q <= 1'b0;
      else                            pos_q    <= pos_q + 1'b1;
      if (sym_ok) begin
        case (pos_q)
          P_LINK: begin
            shadow_q.link_pad <= (cls == SC_PAD);
            shadow_q.link     <= (cls == SC_PAD) ? '0 : sym_data;
          end
          P_LANE: begin
            shadow_q.lane_pad <= (cls == SC_PAD);
            shadow_q.lane     <= (cls == SC_PAD) ? '0 : sym_data;
          end
          P_FTS:  shadow_q.fts    <= sym_data;
          P_RATE: shadow_q.rate   <= sym_data;
          P_CTRL: shadow_q.ctrl   <= sym_data[CTRL_W-1:0];
          P_ID:   shadow_q.is_ts2 <= is_id_ts2;
          default: ;
        endcase
      end
    end
  end

  AST_COM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    com_evt |=> (active_q && pos_q == P_LINK)); // R9

  AST_ID_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pos_q >= P_ID && !is_id_ts1 && !is_id_ts2) |=> !active_q); // R7

  AST_KCHAR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pos_q > P_LANE && pos_q < P_ID && cls != SC_DATA) |=> !active_q); // R8

  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> ($stable(pos_q) && $stable(active_q))); // R11

endmodule

// File: rtl/ts_set_register.sv
module ts_set_register
  import ts_rx_pkg::*;
#(
  parameter int RUN_MAX = 15,
  parameter int RUN_W   = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_evt,
  input  ts_fields_t       fields_i,
  output ts_fields_t       fields_o,
  output logic             valid_o,
  output logic [RUN_W-1:0] run_o,
  output logic             same_evt
);

  localparam logic [RUN_W-1:0] RUN_CAP = RUN_W'(RUN_MAX);

  ts_fields_t       fields_q;
  logic             have_prev_q;
  logic             valid_q;
  logic [RUN_W-1:0] run_q;

  assign same_evt = have_prev_q && (fields_i == fields_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q    <= '0;
      have_prev_q <= 1'b0;
      valid_q     <= 1'b0;
      run_q       <= '0;
    end else begin
      valid_q <= done_evt;
      if (done_evt) begin
        fields_q    <= fields_i;
        have_prev_q <= 1'b1;
        run_q       <= RUN_W'(next_run(32'(run_q), RUN_MAX, same_evt));
      end
    end
  end

  assign fields_o = fields_q;
  assign valid_o  = valid_q;
  assign run_o    = run_q;

  AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !same_evt) |=> (run_o == '0)); // R10

  AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && same_evt && run_q < RUN_CAP) |=> (run_o == $past(run_q) + 1'b1)); // R10

  AST_RUN_HELD_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && same_evt && run_q == RUN_CAP) |=> (run_o == RUN_CAP)); // R10

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !done_evt |=> ($stable(fields_o) && $stable(run_o))); // R12

endmodule

// File: rtl/ts_rx.sv
module ts_rx
  import ts_rx_pkg::*;
#(
  parameter int SET_LEN = 16,
  parameter int RUN_MAX = 15
)(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             sym_valid,
  input  logic                             sym_k,
  input  logic [7:0]                       sym_data,
  output logic                             set_valid,
  output logic                             set_is_ts2,
  output logic [7:0]                       link_num,
  output logic                             link_pad,
  output logic [7:0]                       lane_num,
  output logic                             lane_pad,
  output logic [7:0]                       fts_num,
  output logic [7:0]                       rate_code,
  output logic [3:0]                       train_ctrl,
  output logic [$clog2(RUN_MAX+1)-1:0]     run_count,
  output logic                             scr_reset
);

  localparam int RUN_W = $clog2(RUN_MAX + 1);

  sym_class_e cls;
  logic       is_id_ts1, is_id_ts2;
  logic       com_evt, done_evt, abort_evt, same_evt;
  ts_fields_t parsed, held;
  logic       scr_q;

  ts_sym_classify u_cls (
    .sym_k     (sym_k),
    .sym_data  (sym_data),
    .cls       (cls),
    .is_id_ts1 (is_id_ts1),
    .is_id_ts2 (is_id_ts2)
  );

  ts_frame_parser #(.SET_LEN(SET_LEN)) u_parse (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .cls       (cls),
    .sym_data  (sym_data),
    .is_id_ts1 (is_id_ts1),
    .is_id_ts2 (is_id_ts2),
    .com_evt   (com_evt),
    .done_evt  (done_evt),
    .abort_evt (abort_evt),
    .fields_o  (parsed)
  );

  ts_set_register #(.RUN_MAX(RUN_MAX), .RUN_W(RUN_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_evt (done_evt),
    .fields_i (parsed),
    .fields_o (held),
    .valid_o  (set_valid),
    .run_o    (run_count),
    .same_evt (same_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scr_q <= 1'b0;
    else        scr_q <= com_evt;
  end

  assign scr_reset  = scr_q;
  assign set_is_ts2 = held.is_ts2;
  assign link_num   = held.link;
  assign link_pad   = held.link_pad;
  assign lane_num   = held.lane;
  assign lane_pad   = held.lane_pad;
  assign fts_num    = held.fts;
  assign rate_code  = held.rate;
  assign train_ctrl = held.ctrl;

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |=> !set_valid); // R3

  AST_SCR_AFTER_COM: assert property (@(posedge clk) disable iff (!rst_n)
    com_evt |=> scr_reset); // R2

  AST_SCR_ONLY_COM: assert property (@(posedge clk) disable iff (!rst_n)
    !com_evt |=> !scr_reset); // R2

  AST_ABORT_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !set_valid); // R7

  AST_LINK_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    link_pad |-> (link_num == 8'h00)); // R4

  AST_LANE_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lane_pad |-> (lane_num == 8'h00)); // R5

endmodule

// File: tb/ts_rx_test.sv
`timescale 1ns/1ps
module ts_rx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0;
  logic       sym_k = 1'b0;
  logic [7:0] sym_data = 8'h00;
  logic       set_valid, set_is_ts2, link_pad, lane_pad, scr_reset;
  logic [7:0] link_num, lane_num, fts_num, rate_code;
  logic [3:0] train_ctrl, run_count;

  always #2 clk = ~clk;

  ts_rx uut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_k(sym_k), .sym_data(sym_data),
    .set_valid(set_valid), .set_is_ts2(set_is_ts2), .link_num(link_num), .link_pad(link_pad),
    .lane_num(lane_num), .lane_pad(lane_pad), .fts_num(fts_num), .rate_code(rate_code),
    .train_ctrl(train_ctrl), .run_count(run_count), .scr_reset(scr_reset)
  );

  typedef struct {
    bit ts2; bit lpad; logic [7:0] link; bit npad; logic [7:0] lane;
    logic [7:0] fts; logic [7:0] rate; logic [3:0] ctrl; int cnt;
  } exp_t;

  int   n_tests = 0, n_fail = 0;
  int   com_sent = 0, scr_seen = 0;
  bit   started = 0;
  exp_t exp_q[$];
  exp_t last_e;
  bit   have_last = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected-set model: R10 run rule, R4/R5 PAD zeroing, R6 low ctrl bits
  task automatic model_push(bit ts2, bit lpad, logic [7:0] link, bit npad, logic [7:0] lane,
                            logic [7:0] fts, logic [7:0] rate, logic [7:0] s5);
    exp_t e;
    bit same;
    e.ts2 = ts2; e.lpad = lpad; e.link = lpad ? 8'h00 : link;
    e.npad = npad; e.lane = npad ? 8'h00 : lane;
    e.fts = fts; e.rate = rate; e.ctrl = s5[3:0];
    same = have_last && e.ts2 == last_e.ts2 && e.lpad == last_e.lpad && e.link == last_e.link &&
           e.npad == last_e.npad && e.lane == last_e.lane && e.fts == last_e.fts &&
           e.rate == last_e.rate && e.ctrl == last_e.ctrl;
    e.cnt = !same ? 0 : (last_e.cnt >= 15 ? 15 : last_e.cnt + 1);
    last_e = e; have_last = 1;
    exp_q.push_back(e);
  endtask

  task automatic put(bit k, logic [7:0] d, bit gap);
    @(negedge clk);
    sym_valid = 1'b1; sym_k = k; sym_data = d;
    if (k && d == 8'hBC) com_sent++;
    if (gap) begin
      @(negedge clk);
      sym_valid = 1'b0; sym_k = 1'b1; sym_data = 8'hBC; // R11: ignored COM
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      sym_valid = 1'b0; sym_k = 1'b0; sym_data = 8'h00;
    end
  endtask

  task automatic send_set(bit ts2, bit lpad, logic [7:0] link, bit npad, logic [7:0] lane,
                          logic [7:0] fts, logic [7:0] rate, logic [7:0] s5, bit gap,
                          int bad_pos, bit bad_k, logic [7:0] bad_d);
    logic [7:0] id;
    id = ts2 ? 8'h45 : 8'h4A;
    for (int p = 0; p < 16; p++) begin
      bit k; logic [7:0] d;
      case (p)
        0: begin k = 1; d = 8'hBC; end
        1: begin k = lpad; d = lpad ? 8'hF7 : link; end
        2: begin k = npad; d = npad ? 8'hF7 : lane; end
        3: begin k = 0; d = fts; end
        4: begin k = 0; d = rate; end
        5: begin k = 0; d = s5; end
        default: begin k = 0; d = id; end
      endcase
      if (p == bad_pos) begin k = bad_k; d = bad_d; end
      if (p == 15 && bad_pos < 0) model_push(ts2, lpad, link, npad, lane, fts, rate, s5);
      put(k, d, gap);
    end
  endtask

  task automatic check_held(string req);
    idle(2);
    chk(req, "run_count held", int'(run_count), last_e.cnt);
    chk(req, "link_num held", int'(link_num), int'(last_e.link));
  endtask

  // Monitor: pops expected sets as set_valid appears
  always @(negedge clk) begin
    if (started) begin
      if (scr_reset) scr_seen++;
      if (set_valid) begin
        if (exp_q.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL R7 unexpected set_valid: actual 1 expected 0");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk("R3", "set_is_ts2", int'(set_is_ts2), int'(e.ts2));
          chk("R4", "link_pad",   int'(link_pad),   int'(e.lpad));
          chk("R4", "link_num",   int'(link_num),   int'(e.link));
          chk("R5", "lane_pad",   int'(lane_pad),   int'(e.npad));
          chk("R5", "lane_num",   int'(lane_num),   int'(e.lane));
          chk("R6", "fts_num",    int'(fts_num),    int'(e.fts));
          chk("R6", "rate_code",  int'(rate_code),  int'(e.rate));
          chk("R6", "train_ctrl", int'(train_ctrl), int'(e.ctrl));
          chk("R10", "run_count", int'(run_count),  e.cnt);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset state
    chk("R1", "set_valid", int'(set_valid), 0);
    chk("R1", "scr_reset", int'(scr_reset), 0);
    chk("R1", "run_count", int'(run_count), 0);
    chk("R1", "link_num",  int'(link_num), 0);
    chk("R1", "link_pad",  int'(link_pad), 0);
    chk("R1", "train_ctrl", int'(train_ctrl), 0);
    @(negedge clk); rst_n = 1'b1; started = 1;

    // R4/R5 PAD fields, TS1, then repeat for R10
    send_set(0, 1, 8'h00, 1, 8'h00, 8'h20, 8'h02, 8'h00, 0, -1, 0, 8'h00);
    send_set(0, 1, 8'h00, 1, 8'h00, 8'h20, 8'h02, 8'h00, 0, -1, 0, 8'h00);
    // TS2 numeric fields; R6 upper ctrl bits ignored
    send_set(1, 0, 8'h05, 0, 8'h03, 8'h80, 8'h06, 8'hF5, 0, -1, 0, 8'h00);
    send_set(1, 0, 8'h05, 0, 8'h03, 8'h80, 8'h06, 8'h05, 0, -1, 0, 8'h00);
    // R11 gaps with a stray COM on the idle cycles
    send_set(1, 0, 8'h05, 0, 8'h03, 8'h80, 8'h06, 8'h05, 1, -1, 0, 8'h00);
    idle(2);
    chk("R11", "run after gapped set", int'(run_count), 2);

    // R7 mixed identifier and foreign identifier
    send_set(1, 0, 8'h05, 0, 8'h03, 8'h80, 8'h06, 8'h05, 0, 9, 0, 8'h4A);
    check_held("R7");
    send_set(1, 0, 8'h05, 0, 8'h03, 8'h80, 8'h06, 8'h05, 0, 6, 0, 8'h00);
    check_held("R7");
    send_set(1, 0, 8'h05, 0, 8'h03, 8'h80, 8'h06, 8'h05, 0, 15, 1, 8'h45);
    check_held("R7");
    // R8 stray control characters
    send_set(1, 0, 8'h05, 0, 8'h03, 8'h80, 8'h06, 8'h05, 0, 1, 1, 8'h1C);
    check_held("R8");
    send_set(1, 0, 8'h05, 0, 8'h03, 8'h80, 8'h06, 8'h05, 0, 3, 1, 8'hF7);
    check_held("R8");
    // R10 dropped sets keep the chain
    send_set(1, 0, 8'h05, 0, 8'h03, 8'h80, 8'h06, 8'h05, 0, -1, 0, 8'h00);

    // R9 COM at symbol 8: following identifiers become symbols 1..7
    send_set(0, 0, 8'h11, 0, 8'h22, 8'h33, 8'h44, 8'h01, 0, 8, 1, 8'hBC);
    model_push(0, 0, 8'h4A, 0, 8'h4A, 8'h4A, 8'h4A, 8'h4A);
    for (int i = 0; i < 8; i++) put(0, 8'h4A, 0);

    // R10 saturation
    for (int i = 0; i < 17; i++)
      send_set(0, 0, 8'h01, 0, 8'h00, 8'h10, 8'h02, 8'h08, 0, -1, 0, 8'h00);
    idle(2);
    chk("R10", "saturated run", int'(run_count), 15);
    send_set(0, 0, 8'h01, 0, 8'h01, 8'h10, 8'h02, 8'h08, 0, -1, 0, 8'h00);

    idle(5);
    chk("R12", "fields held after idle", int'(lane_num), 1);
    chk("R3", "sets left unreceived", exp_q.size(), 0);
    chk("R2", "scr_reset pulses vs COMs", scr_seen, com_sent);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule